// File: doc/BRIEF.md
# Power Management I/O Window Decoder

This block holds the small set of configuration bytes that place two 64-byte I/O windows in a 16-bit I/O space. One window fronts the power-management register file and the other fronts the SMBus host register file. For every incoming I/O address it reports whether the address falls inside either window and, if it does, the byte offset inside that window. The register files behind the windows and the configuration-cycle protocol that feeds the write and read ports are not part of this block.

Configuration writes are dword-addressed with four byte enables, so a single write can touch any subset of a dword's bytes. Each window has a 32-bit base dword and a separate enable byte. Only bits [15:6] of the base dword take part in the decode. Bit 0 of the enable byte switches the window on. A window's decode registers are reloaded whenever a write touches its base dword or its enable byte. The new placement therefore applies to I/O decode from the cycle after the write edge.

Top module: `pmio_window_decode`

## Requirements
- R1: After reset, the PM base dword (config offset 0x40, dword index 0x10) reads 0x00000001. The PM enable dword (offset 0x80, index 0x20) reads 0, so the PM window never hits. The SMBus base dword (offset 0x90, index 0x24) reads 0x00000100. The SMBus enable dword (offset 0xD0, index 0x34) reads 0x00090000: byte 0xD2 holds 0x09, so the SMBus window is enabled at 0x0100–0x013F.
- R2: A write changes only the bytes whose enable bit is set. Lane i covers data bits [8i+7:8i], and a bus write addresses dword index = config offset >> 2.
- R3: Bit 0 of config byte 0x40 ignores writes and always reads back as 1.
- R4: The PM window hits when it is enabled and io_addr[15:6] equals bits [15:6] of the PM base dword. Base bits [5:0] and [31:16] are stored and read back but do not affect the decode.
- R5: Only bit 0 of config byte 0x80 (lane 0 of dword 0x20) enables the PM window. The other bits of that byte are stored but have no effect. The other three bytes of that dword read as 0 and ignore writes.
- R6: The SMBus window hits when bit 0 of config byte 0xD2 (lane 2, data bit 16 of dword 0x34) is set and io_addr[15:6] equals bits [15:6] of the SMBus base dword. Lanes 0, 1 and 3 of dword 0x34 read as 0 and ignore writes.
- R7: While a window hits, its offset output equals io_addr[5:0]. While it does not hit, its offset output is 0.
- R8: When both windows are enabled and cover the same address, only pm_hit is raised.
- R9: A configuration write changes the decode starting from the cycle after the write's clock edge. Without a write, the decode depends only on io_addr.
- R10: A read of any dword index other than 0x10, 0x20, 0x24 and 0x34 returns 0. A write there changes neither the decode nor any readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Dword index of the write (config offset >> 2) |
| cfg_wr_data | input | 32 | Write data, little-endian byte lanes |
| cfg_wr_be | input | 4 | Byte-lane enables of the write |
| cfg_rd_dw | input | 6 | Dword index to read |
| cfg_rd_data | output | 32 | Read data of that dword (combinational) |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the PM window |
| pm_ofs | output | 6 | Offset within the PM window |
| smb_hit | output | 1 | Address falls in the SMBus window (and not in the PM window) |
| smb_ofs | output | 6 | Offset within the SMBus window |

## Verification
The hardest situation to reach from the ports is two enabled windows landing on the same 64-byte block while other bits of their base dwords differ. That case needs a sequence of partial-lane writes. Because of the read-only bit and the ignored lanes, the value a write leaves behind is not the value written. The bench keeps a byte-lane model of every configuration dword, applies each write to it under the stated read-only masks, and then sweeps all 1024 window positions of the I/O space. It repeats the sweep after each write, including writes that should change nothing, and after a series of base placements that walk across the address space.

// File: rtl/pmio_pkg.sv
package pmio_pkg;

  localparam int CFG_DW_W = 6;

  typedef logic [31:0] cfg_dword_t;

  // Merge a byte-enabled write into a held dword; bits in ro keep cur.
  function automatic cfg_dword_t lane_merge(input cfg_dword_t cur,
                                            input cfg_dword_t wr,
                                            input logic [3:0] be,
                                            input cfg_dword_t ro);
    cfg_dword_t m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return (((cur & ~m) | (wr & m)) & ~ro) | (cur & ro);
  endfunction

endpackage

// File: rtl/pmio_cfg_field.sv
module pmio_cfg_field
  import pmio_pkg::*;
#(
  parameter int              DW_W    = CFG_DW_W,
  parameter logic [DW_W-1:0] DW_IDX  = '0,
  parameter cfg_dword_t      RST_VAL = '0,
  parameter cfg_dword_t      RO_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW_W-1:0] wr_dw,
  input  cfg_dword_t      wr_data,
  input  logic [3:0]      wr_be,
  output logic            sel,
  output cfg_dword_t      nxt,
  output cfg_dword_t      q
);

  always_comb begin
    sel = wr_en && (wr_dw == DW_IDX);
    nxt = sel ? lane_merge(q, wr_data, wr_be, RO_MASK) : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST_VAL;
    else if (sel) q <= nxt;
  end

endmodule

// File: rtl/pmio_win_reg.sv
module pmio_win_reg #(
  parameter int                          IO_AW    = 16,
  parameter int                          WIN_LOG2 = 6,
  parameter logic [IO_AW-WIN_LOG2-1:0]   RST_BASE = '0,
  parameter logic                        RST_EN   = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [IO_AW-1:WIN_LOG2]     base_in,
  input  logic                        en_in,
  input  logic [IO_AW-1:0]            io_addr,
  output logic                        hit,
  output logic [WIN_LOG2-1:0]         ofs
);

  localparam int TAG_W = IO_AW - WIN_LOG2;

  logic [TAG_W-1:0] base_q, base_d;
  logic             en_q, en_d;

  always_comb begin
    base_d = load ? base_in : base_q;
    en_d   = load ? en_in   : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RST_BASE;
      en_q   <= RST_EN;
    end else if (load) begin
      base_q <= base_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    hit = en_q && (io_addr[IO_AW-1:WIN_LOG2] == base_q);
    ofs = hit ? io_addr[WIN_LOG2-1:0] : '0;
  end

endmodule

// File: rtl/pmio_window_decode.sv
module pmio_window_decode
  import pmio_pkg::*;
#(
  parameter int         IO_AW        = 16,
  parameter int         WIN_LOG2     = 6,
  parameter logic [7:0] PM_BASE_OFS  = 8'h40,
  parameter logic [7:0] PM_EN_OFS    = 8'h80,
  parameter logic [7:0] SMB_BASE_OFS = 8'h90,
  parameter logic [7:0] SMB_EN_OFS   = 8'hD2,
  parameter cfg_dword_t SMB_BASE_RST = 32'h0000_0100,
  parameter logic [7:0] SMB_EN_RST   = 8'h09
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [CFG_DW_W-1:0] cfg_wr_dw,
  input  logic [31:0]         cfg_wr_data,
  input  logic [3:0]          cfg_wr_be,
  input  logic [CFG_DW_W-1:0] cfg_rd_dw,
  output logic [31:0]         cfg_rd_data,
  input  logic [IO_AW-1:0]    io_addr,
  output logic                pm_hit,
  output logic [WIN_LOG2-1:0] pm_ofs,
  output logic                smb_hit,
  output logic [WIN_LOG2-1:0] smb_ofs
);

  localparam int NWIN = 2;

  logic [NWIN-1:0][31:0]         base_q_a, en_q_a;
  logic [NWIN-1:0][CFG_DW_W-1:0] base_dw_a, en_dw_a;
  logic [NWIN-1:0]               raw_hit;
  logic [NWIN-1:0][WIN_LOG2-1:0] raw_ofs;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [7:0] BOFS  = (w == 0) ? PM_BASE_OFS : SMB_BASE_OFS;
    localparam logic [7:0] EOFS  = (w == 0) ? PM_EN_OFS   : SMB_EN_OFS;
    localparam int         ELANE = int'(EOFS[1:0]);
    localparam logic [CFG_DW_W-1:0] BDW = BOFS[7:2];
    localparam logic [CFG_DW_W-1:0] EDW = EOFS[7:2];
    localparam cfg_dword_t B_RST = (w == 0) ? 32'h0000_0001 : SMB_BASE_RST;
    localparam cfg_dword_t B_RO  = (w == 0) ? 32'h0000_0001 : 32'h0;
    localparam logic [7:0] E_BYTE = (w == 0) ? 8'h00 : SMB_EN_RST;
    localparam cfg_dword_t E_RST = cfg_dword_t'(E_BYTE) << (8 * ELANE);
    localparam cfg_dword_t E_RO  = ~(cfg_dword_t'(8'hFF) << (8 * ELANE));

    logic       b_sel, e_sel, load;
    cfg_dword_t b_nxt, e_nxt, b_q, e_q;

    pmio_cfg_field #(.DW_W(CFG_DW_W), .DW_IDX(BDW), .RST_VAL(B_RST),
                     .RO_MASK(B_RO)) u_base (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
      .wr_data(cfg_wr_data), .wr_be(cfg_wr_be),
      .sel(b_sel), .nxt(b_nxt), .q(b_q)
    );

    pmio_cfg_field #(.DW_W(CFG_DW_W), .DW_IDX(EDW), .RST_VAL(E_RST),
                     .RO_MASK(E_RO)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
      .wr_data(cfg_wr_data), .wr_be(cfg_wr_be),
      .sel(e_sel), .nxt(e_nxt), .q(e_q)
    );

    // Reload the decode when the write touches the base dword or enable byte.
    assign load = (b_sel && (|cfg_wr_be)) || (e_sel && cfg_wr_be[ELANE]);

    pmio_win_reg #(.IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2),
                   .RST_BASE(B_RST[IO_AW-1:WIN_LOG2]),
                   .RST_EN(E_RST[8*ELANE])) u_win (
      .clk(clk), .rst_n(rst_n), .load(load),
      .base_in(b_nxt[IO_AW-1:WIN_LOG2]), .en_in(e_nxt[8*ELANE]),
      .io_addr(io_addr), .hit(raw_hit[w]), .ofs(raw_ofs[w])
    );

    assign base_q_a[w]  = b_q;
    assign en_q_a[w]    = e_q;
    assign base_dw_a[w] = BDW;
    assign en_dw_a[w]   = EDW;
  end

  always_comb begin
    cfg_rd_data = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (cfg_rd_dw == base_dw_a[w]) cfg_rd_data = base_q_a[w];
      if (cfg_rd_dw == en_dw_a[w])   cfg_rd_data = en_q_a[w];
    end
  end

  // PM window wins over SMBus on overlap.
  always_comb begin
    pm_hit  = raw_hit[0];
    pm_ofs  = raw_ofs[0];
    smb_hit = raw_hit[1] && !raw_hit[0];
    smb_ofs = smb_hit ? raw_ofs[1] : '0;
  end

endmodule

// File: rtl/pmio_window_decode_chk.sv
module pmio_window_decode_chk #(
  parameter int         IO_AW       = 16,
  parameter int         WIN_LOG2    = 6,
  parameter logic [7:0] PM_BASE_OFS = 8'h40,
  parameter logic [7:0] PM_EN_OFS   = 8'h80,
  parameter logic [7:0] SMB_EN_OFS  = 8'hD2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr_en,
  input logic [5:0]          cfg_wr_dw,
  input logic [31:0]         cfg_wr_data,
  input logic [3:0]          cfg_wr_be,
  input logic [5:0]          cfg_rd_dw,
  input logic [31:0]         cfg_rd_data,
  input logic [IO_AW-1:0]    io_addr,
  input logic                pm_hit,
  input logic [WIN_LOG2-1:0] pm_ofs,
  input logic                smb_hit,
  input logic [WIN_LOG2-1:0] smb_ofs
);

  localparam int PL = int'(PM_EN_OFS[1:0]);
  localparam int SL = int'(SMB_EN_OFS[1:0]);

  // R8
  no_dual_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_hit && smb_hit));

  // R3
  ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_dw == PM_BASE_OFS[7:2]) |-> cfg_rd_data[0]);

  // R5
  pm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_dw == PM_EN_OFS[7:2] && cfg_wr_be[PL] &&
     !cfg_wr_data[8*PL]) |=> !pm_hit);

  // R6
  smb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_dw == SMB_EN_OFS[7:2] && cfg_wr_be[SL] &&
     !cfg_wr_data[8*SL]) |=> !smb_hit);

  // R7
  idle_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!pm_hit) |-> (pm_ofs == '0)) and ((!smb_hit) |-> (smb_ofs == '0)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_wr_en) && $stable(io_addr)) |->
      ($stable(pm_hit) && $stable(smb_hit) && $stable(pm_ofs) &&
       $stable(smb_ofs)));

endmodule

bind pmio_window_decode pmio_window_decode_chk #(
  .IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2), .PM_BASE_OFS(PM_BASE_OFS),
  .PM_EN_OFS(PM_EN_OFS), .SMB_EN_OFS(SMB_EN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
  .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .cfg_rd_dw(cfg_rd_dw),
  .cfg_rd_data(cfg_rd_data), .io_addr(io_addr), .pm_hit(pm_hit),
  .pm_ofs(pm_ofs), .smb_hit(smb_hit), .smb_ofs(smb_ofs)
);

// File: tb/tb_pmio_window_decode.sv
`timescale 1ns/100ps
module tb_pmio_window_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_wr_dw = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0]  cfg_wr_be = '0;
  logic [5:0]  cfg_rd_dw = '0;
  logic [31:0] cfg_rd_data;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [5:0]  pm_ofs, smb_ofs;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // model of the held dwords
  logic [31:0] m_pmb = 32'h1, m_pme = 32'h0, m_smb = 32'h100, m_sme = 32'h0009_0000;

  always #2.5 clk = ~clk;

  pmio_window_decode dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
    .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .cfg_rd_dw(cfg_rd_dw),
    .cfg_rd_data(cfg_rd_data), .io_addr(io_addr), .pm_hit(pm_hit),
    .pm_ofs(pm_ofs), .smb_hit(smb_hit), .smb_ofs(smb_ofs)
  );

  function automatic logic [31:0] merge(logic [31:0] cur, logic [31:0] d,
                                        logic [3:0] be, logic [31:0] ro);
    logic [31:0] r = cur;
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 8; b++)
        if (be[i] && !ro[8*i+b]) r[8*i+b] = d[8*i+b];
    return r;
  endfunction

  function automatic logic [13:0] expect_dec(logic [15:0] a);
    logic ph, sh;
    ph = m_pme[0]  && (a[15:6] == m_pmb[15:6]);
    sh = m_sme[16] && (a[15:6] == m_smb[15:6]) && !ph;
    return {ph, ph ? a[5:0] : 6'd0, sh, sh ? a[5:0] : 6'd0};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] dw, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_data = d; cfg_wr_be = be;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    case (dw)
      6'h10: m_pmb = merge(m_pmb, d, be, 32'h0000_0001);
      6'h20: m_pme = merge(m_pme, d, be, 32'hFFFF_FF00);
      6'h24: m_smb = merge(m_smb, d, be, 32'h0);
      6'h34: m_sme = merge(m_sme, d, be, 32'hFF00_FFFF);
      default: ;
    endcase
  endtask

  task automatic read_chk(string tag, logic [5:0] dw, logic [31:0] exp);
    cfg_rd_dw = dw;
    #1;
    check(tag, cfg_rd_data, exp);
  endtask

  task automatic readback_all(string tag);
    read_chk(tag, 6'h10, m_pmb);
    read_chk(tag, 6'h20, m_pme);
    read_chk(tag, 6'h24, m_smb);
    read_chk(tag, 6'h34, m_sme);
  endtask

  // every 64-byte block of the I/O space, with a moving in-window offset
  task automatic sweep(string tag);
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      io_addr = {k[9:0], 6'(k * 5 + 3)};
      #1;
      check(tag, {18'd0, pm_hit, pm_ofs, smb_hit, smb_ofs},
            {18'd0, expect_dec(io_addr)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    readback_all("R1");
    for (int o = 0; o < 64; o += 21) begin
      io_addr = 16'h0100 + 16'(o); #1;
      check("R1", {pm_hit, smb_hit, 2'b0, smb_ofs}, {1'b0, 1'b1, 2'b0, 6'(o)});
    end
    sweep("R1");

    // R2 R3 full write to PM base, window still disabled (R5)
    cfg_write(6'h10, 32'h0000_1234, 4'hF);
    read_chk("R3", 6'h10, 32'h0000_1235);
    sweep("R5");

    // R4 enable PM window, R9 immediately after the write edge
    cfg_write(6'h20, 32'h0000_0001, 4'h1);
    sweep("R4");

    // R5 other bits of the enable byte alone do not enable; upper lanes RO
    cfg_write(6'h20, 32'hFFFF_FFFE, 4'hF);
    read_chk("R5", 6'h20, 32'h0000_00FE);
    sweep("R5");
    cfg_write(6'h20, 32'h0000_0003, 4'h1);

    // R3 lane 0 write of zero keeps bit 0; R2 lane 1 only
    cfg_write(6'h10, 32'h0000_0000, 4'h1);
    read_chk("R3", 6'h10, 32'h0000_1201);
    cfg_write(6'h10, 32'h5555_0155, 4'h2);
    read_chk("R2", 6'h10, 32'h0000_0101);
    // R8 both windows at 0x0100
    sweep("R8");

    // R4 high half of the base dword stored, ignored by decode
    cfg_write(6'h10, 32'hFFFF_0000, 4'hC);
    readback_all("R4");
    sweep("R4");

    // R6 disable SMBus, then lanes other than 2 ignore writes
    cfg_write(6'h10, 32'h0000_2000, 4'hF);
    cfg_write(6'h34, 32'h0000_0000, 4'h4);
    sweep("R6");
    cfg_write(6'h34, 32'hFFFF_FFFF, 4'hB);
    read_chk("R6", 6'h34, 32'h0000_0000);
    sweep("R6");
    cfg_write(6'h34, 32'h00FF_0000, 4'h4);
    cfg_write(6'h24, 32'h0000_7FFF, 4'h3);
    readback_all("R6");
    sweep("R7");

    // R10 unimplemented dwords
    cfg_write(6'h11, 32'hFFFF_FFFF, 4'hF);
    cfg_write(6'h35, 32'hFFFF_FFFF, 4'hF);
    read_chk("R10", 6'h11, 32'h0);
    read_chk("R10", 6'h21, 32'h0);
    read_chk("R10", 6'h35, 32'h0);
    readback_all("R10");
    sweep("R10");

    // R9 series of placements walking the address space
    for (int b = 0; b < 12; b++) begin
      cfg_write(6'h10, 32'(b * 16'h1540 + 16'h003E), 4'h3);
      cfg_write(6'h24, 32'(16'hF000 - b * 16'h0A40 + 16'h0015), 4'h3);
      if (b == 6) cfg_write(6'h24, m_pmb, 4'h3);
      readback_all("R9");
      sweep("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog got=%0d exp<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule